// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block is the issue stage of a small SIMT core. It keeps a program counter, a lane mask and a reconvergence stack for each of several warps, and each cycle it picks one warp to issue. The issued warp's current instruction goes to every lane that is set in the warp's mask. Selection is round-robin among the warps that are ready. A warp is ready when it has been launched and its memory-pending flag is low. Any warp can issue on any cycle, so changing from one warp to another costs no cycles.

The instruction fetch and decode stages outside the block present a branch descriptor for each warp:
- a branch flag
- a per-lane taken vector
- a target PC
- a reconvergence PC

When the active lanes of the issued warp disagree on a branch, the block saves the fall-through state on that warp's stack and runs the taken path first under a reduced mask. When the taken path reaches the reconvergence PC, the block runs the fall-through path. When that path reaches the reconvergence PC, the block restores the mask the warp had before the branch.

The issue outputs are combinational from the current state and the ready flags. Warp state advances on the clock edge that ends the issue cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After a synchronous active-low reset, no warp is launched, `issue_valid` is 0 and `overflow_err` is 0.
- R2: A launch of warp w loads its PC from `launch_pc` and its mask from `launch_mask`, and clears its stack. From the next cycle the warp is eligible to issue. A launch takes priority over an issue of the same warp.
- R3: In a cycle with `issue_valid`=1, `issue_warp`, `issue_pc` and `issue_mask` show the selected warp's state in that same cycle. If that warp's branch flag is 0, its PC is one higher in the next cycle.
- R4: Among ready warps, the one granted is the first found when searching upward, with wraparound, from the warp after the last warp that issued. After reset the search starts at warp 0.
- R5: A warp whose `mem_pending` bit is set is never issued. When no warp is ready, `issue_valid`=0 and no PC or mask changes.
- R6: A branch on which all active lanes agree leaves the mask unchanged and pushes nothing. If all active lanes take the branch, the next PC is the target. If none does, the next PC is the branch PC plus 1.
- R7: A branch on which the active lanes split pushes one stack entry. The next PC is the target, and the next mask is the active lanes that took the branch.
- R8: When the next PC of a warp equals the reconvergence PC of its top stack entry and that entry is still on its taken path, the warp moves to the branch PC plus 1, with the active lanes that did not take the branch.
- R9: When the next PC equals the top entry's reconvergence PC on the fall-through path, the entry is popped. The warp then continues at the reconvergence PC with the mask it had before the branch.
- R10: Nested divergent branches stack up to STACK_DEPTH (default 4) entries per warp, and they unwind innermost first.
- R11: A divergent branch on a full stack sets `overflow_err`. The flag stays set until reset, even across launches. The push is dropped, and the warp continues on the taken path with the taken mask.
- R12: With several warps ready, consecutive cycles issue different warps with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Start the warp named by `launch_warp` |
| launch_warp | input | WID_W | Index of the warp to launch |
| launch_pc | input | PC_W | Start PC of the launched warp |
| launch_mask | input | LANES | Initial lane mask of the launched warp |
| mem_pending | input | NUM_WARPS | Per-warp stall flag for outstanding memory data |
| br_is_branch | input | NUM_WARPS | Per-warp flag: the current instruction is a branch |
| br_taken_lanes | input | NUM_WARPS*LANES | Per-warp taken vector, one bit per lane, warp w at bits [w*LANES +: LANES] |
| br_target_pc | input | NUM_WARPS*PC_W | Per-warp branch target, warp w at [w*PC_W +: PC_W] |
| br_reconv_pc | input | NUM_WARPS*PC_W | Per-warp reconvergence PC, warp w at [w*PC_W +: PC_W] |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | WID_W | Index of the issuing warp |
| issue_pc | output | PC_W | PC of the issued instruction |
| issue_mask | output | LANES | Lanes that execute the issued instruction |
| overflow_err | output | 1 | Sticky flag: a reconvergence stack overflowed |

## Verification
The issue outputs are due in the same cycle as the ready flags that cause them. The bench therefore drives its inputs just after a falling edge and samples the outputs half a cycle later, before the next rising edge. Each PC, mask or flag change caused by an issue is due one rising edge later, so the bench advances exactly one clock between an issue and the check of its result. The round-robin sweep first sets the last-issued warp by letting only that warp issue for one cycle. It then applies every pending pattern and compares the grant with the first ready warp found by stepping upward from that warp.

// File: rtl/warp_sched_pkg.sv
// Package: shared types for the warp issue scheduler.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package warp_sched_pkg;

    // How the active lanes of an issued instruction resolved
    typedef enum logic [1:0] {
        BR_NONE   = 2'd0,
        BR_ALL_TK = 2'd1,
        BR_ALL_NT = 2'd2,
        BR_SPLIT  = 2'd3
    } br_kind_e;

endpackage

// File: rtl/reconv_stack.sv
// Module: reconv_stack
// Per-warp divergence stack. Each entry holds a reconvergence PC, the
// fall-through PC and mask, the pre-branch mask and a phase bit
// (0 = taken path running, 1 = fall-through path running).
// Assumes: the caller never pushes when full; clear has priority over
// push, push over pop, and pop over flip.
module reconv_stack #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 16,
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic             flip,
    input  logic [PC_W-1:0]  push_reconv,
    input  logic [PC_W-1:0]  push_alt_pc,
    input  logic [LANES-1:0] push_alt_mask,
    input  logic [LANES-1:0] push_restore,
    output logic [PC_W-1:0]  top_reconv,
    output logic [PC_W-1:0]  top_alt_pc,
    output logic [LANES-1:0] top_alt_mask,
    output logic [LANES-1:0] top_restore,
    output logic             top_phase,
    output logic             empty,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  reconv_q  [DEPTH];
    logic [PC_W-1:0]  alt_pc_q  [DEPTH];
    logic [LANES-1:0] alt_msk_q [DEPTH];
    logic [LANES-1:0] rest_q    [DEPTH];
    logic [DEPTH-1:0] phase_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign empty   = (count_q == '0);
    assign full    = (count_q == CNT_W'(DEPTH));
    assign top_idx = empty ? '0 : IDX_W'(count_q - 1'b1);
    assign wr_idx  = IDX_W'(count_q);

    // Present the top entry, or zeros when the stack is empty
    always_comb begin
        top_reconv   = empty ? '0 : reconv_q[top_idx];
        top_alt_pc   = empty ? '0 : alt_pc_q[top_idx];
        top_alt_mask = empty ? '0 : alt_msk_q[top_idx];
        top_restore  = empty ? '0 : rest_q[top_idx];
        top_phase    = empty ? 1'b0 : phase_q[top_idx];
    end

    // Depth counter and phase bits
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
            phase_q <= '0;
        end else if (push && !full) begin
            count_q          <= count_q + 1'b1;
            phase_q[wr_idx]  <= 1'b0;
        end else if (pop && !empty) begin
            count_q <= count_q - 1'b1;
        end else if (flip && !empty) begin
            phase_q[top_idx] <= 1'b1;
        end
    end

    // Entry payload storage, written only on push
    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            reconv_q[wr_idx]  <= push_reconv;
            alt_pc_q[wr_idx]  <= push_alt_pc;
            alt_msk_q[wr_idx] <= push_alt_mask;
            rest_q[wr_idx]    <= push_restore;
        end
    end

    // R10: depth never exceeds the configured number of entries
    p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R10: a push on a non-full stack grows it by exactly one
    p_push_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !clear) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/rr_picker.sv
// Module: rr_picker
// Round-robin grant among N requesters. The search starts at the entry
// after the one granted last. The pointer moves only when a grant is made.
// Assumes: req is valid for the whole cycle; grant is combinational.
module rr_picker #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [IDX_W-1:0]     grant_idx,
    output logic                 any
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;

    // Scan upward from last_q+1 with wraparound for the first request
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int cand;
            cand = (int'(last_q) + off) % N;
            if (!any && req[cand]) begin
                any         = 1'b1;
                grant_idx   = IDX_W'(cand);
                grant[cand] = 1'b1;
            end
        end
    end

    // Remember the last granted index; reset points at N-1 so index 0 is first
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= IDX_W'(N - 1);
        else if (any) last_q <= grant_idx;
    end

    // R4: at most one requester granted
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: a grant only ever goes to a requester
    p_grant_is_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

endmodule

// File: rtl/warp_ctx.sv
// Module: warp_ctx
// State of one warp: launch flag, PC, lane mask and reconvergence stack.
// Classifies the warp's current branch against its active mask and works
// out the next PC and mask when the warp issues.
// Assumes: 'issue' is high only in a cycle where this warp was granted.
module warp_ctx
    import warp_sched_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [PC_W-1:0]  launch_pc,
    input  logic [LANES-1:0] launch_mask,
    input  logic             issue,
    input  logic             is_branch,
    input  logic [LANES-1:0] taken_lanes,
    input  logic [PC_W-1:0]  target_pc,
    input  logic [PC_W-1:0]  reconv_pc,
    output logic             enabled,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] mask,
    output logic             ovf_pulse
);
    logic [LANES-1:0] act_taken;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  cand_pc;
    logic [PC_W-1:0]  nxt_pc;
    logic [LANES-1:0] nxt_mask;
    br_kind_e         kind;
    logic             do_push, do_pop, do_flip;
    logic [PC_W-1:0]  top_reconv, top_alt_pc;
    logic [LANES-1:0] top_alt_mask, top_restore;
    logic             top_phase, stk_empty, stk_full;

    assign act_taken = taken_lanes & mask;
    assign seq_pc    = pc + 1'b1;

    // Resolve the branch against the lanes that are active
    always_comb begin
        if (!is_branch)                kind = BR_NONE;
        else if (act_taken == mask)    kind = BR_ALL_TK;
        else if (act_taken == '0)      kind = BR_ALL_NT;
        else                           kind = BR_SPLIT;
    end

    // Next PC/mask and stack action for an issue of this warp
    always_comb begin
        nxt_pc    = pc;
        nxt_mask  = mask;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        do_flip   = 1'b0;
        ovf_pulse = 1'b0;
        cand_pc   = (kind == BR_ALL_TK) ? target_pc : seq_pc;
        if (issue) begin
            if (kind == BR_SPLIT) begin
                nxt_pc   = target_pc;
                nxt_mask = act_taken;
                if (stk_full) ovf_pulse = 1'b1;
                else          do_push   = 1'b1;
            end else begin
                nxt_pc = cand_pc;
                if (!stk_empty && cand_pc == top_reconv) begin
                    if (!top_phase) begin
                        do_flip  = 1'b1;
                        nxt_pc   = top_alt_pc;
                        nxt_mask = top_alt_mask;
                    end else begin
                        do_pop   = 1'b1;
                        nxt_mask = top_restore;
                    end
                end
            end
        end
    end

    // Architectural warp registers: launch wins over issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
            pc      <= '0;
            mask    <= '0;
        end else if (launch) begin
            enabled <= 1'b1;
            pc      <= launch_pc;
            mask    <= launch_mask;
        end else if (issue) begin
            pc      <= nxt_pc;
            mask    <= nxt_mask;
        end
    end

    reconv_stack #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .LANES (LANES)
    ) u_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (launch),
        .push          (do_push && !launch),
        .pop           (do_pop && !launch),
        .flip          (do_flip && !launch),
        .push_reconv   (reconv_pc),
        .push_alt_pc   (seq_pc),
        .push_alt_mask (mask & ~taken_lanes),
        .push_restore  (mask),
        .top_reconv    (top_reconv),
        .top_alt_pc    (top_alt_pc),
        .top_alt_mask  (top_alt_mask),
        .top_restore   (top_restore),
        .top_phase     (top_phase),
        .empty         (stk_empty),
        .full          (stk_full)
    );

    // R5: with no issue and no launch the warp's PC and mask hold
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !launch) |=> ($stable(pc) && $stable(mask)));

    // R6: a unanimous branch with an empty stack keeps the mask
    p_uniform_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !launch && is_branch && stk_empty &&
         ((taken_lanes & mask) == mask || (taken_lanes & mask) == '0))
        |=> $stable(mask));

    // R7: a split branch narrows the mask to a subset of the old one
    p_split_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !launch && kind == BR_SPLIT)
        |=> ((mask & ~$past(mask)) == '0 && mask != $past(mask)));

endmodule

// File: rtl/warp_issue_sched.sv
// Module: warp_issue_sched (top)
// Issue stage of a small SIMT core. It holds NUM_WARPS warp contexts and
// grants one ready warp per cycle in round-robin order. It drives the
// granted warp's PC and lane mask on the issue outputs, and keeps a sticky
// flag for reconvergence stack overflow.
// Assumes: the branch descriptor inputs describe each warp's instruction at
// its current PC, and are valid in the cycle the warp issues.
module warp_issue_sched #(
    parameter int NUM_WARPS   = 4,
    parameter int LANES       = 32,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 4,
    localparam int WID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch_valid,
    input  logic [WID_W-1:0]           launch_warp,
    input  logic [PC_W-1:0]            launch_pc,
    input  logic [LANES-1:0]           launch_mask,
    input  logic [NUM_WARPS-1:0]       mem_pending,
    input  logic [NUM_WARPS-1:0]       br_is_branch,
    input  logic [NUM_WARPS*LANES-1:0] br_taken_lanes,
    input  logic [NUM_WARPS*PC_W-1:0]  br_target_pc,
    input  logic [NUM_WARPS*PC_W-1:0]  br_reconv_pc,
    output logic                       issue_valid,
    output logic [WID_W-1:0]           issue_warp,
    output logic [PC_W-1:0]            issue_pc,
    output logic [LANES-1:0]           issue_mask,
    output logic                       overflow_err
);
    logic [NUM_WARPS-1:0] enabled;
    logic [NUM_WARPS-1:0] ready;
    logic [NUM_WARPS-1:0] grant;
    logic [NUM_WARPS-1:0] ovf;
    logic [PC_W-1:0]      pc_arr   [NUM_WARPS];
    logic [LANES-1:0]     mask_arr [NUM_WARPS];

    assign ready = enabled & ~mem_pending;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        warp_ctx #(
            .LANES (LANES),
            .PC_W  (PC_W),
            .DEPTH (STACK_DEPTH)
        ) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .launch      (launch_valid && launch_warp == WID_W'(w)),
            .launch_pc   (launch_pc),
            .launch_mask (launch_mask),
            .issue       (grant[w]),
            .is_branch   (br_is_branch[w]),
            .taken_lanes (br_taken_lanes[w*LANES +: LANES]),
            .target_pc   (br_target_pc[w*PC_W +: PC_W]),
            .reconv_pc   (br_reconv_pc[w*PC_W +: PC_W]),
            .enabled     (enabled[w]),
            .pc          (pc_arr[w]),
            .mask        (mask_arr[w]),
            .ovf_pulse   (ovf[w])
        );
    end

    rr_picker #(
        .N (NUM_WARPS)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ready),
        .grant     (grant),
        .grant_idx (issue_warp),
        .any       (issue_valid)
    );

    // Present the granted warp's state on the issue outputs
    always_comb begin
        issue_pc   = pc_arr[issue_warp];
        issue_mask = mask_arr[issue_warp];
    end

    // Sticky overflow flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)      overflow_err <= 1'b0;
        else if (|ovf)   overflow_err <= 1'b1;
    end

    // R11: once set, the overflow flag never clears without reset
    p_no_overflow_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    // R5: the issuing warp never has memory pending
    p_issue_not_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !mem_pending[issue_warp]);

    // R2: only a launched warp can issue
    p_issue_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> enabled[issue_warp]);

endmodule

// File: tb/warp_issue_sched_test.sv
// Bench for warp_issue_sched: directed divergence/nesting scenarios on one
// warp, then an exhaustive round-robin sweep over last-issued x pending.
module warp_issue_sched_test;
    localparam int NW = 4;
    localparam int LN = 32;
    localparam int PW = 16;
    localparam int WW = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              launch_valid;
    logic [WW-1:0]     launch_warp;
    logic [PW-1:0]     launch_pc;
    logic [LN-1:0]     launch_mask;
    logic [NW-1:0]     mem_pending;
    logic [NW-1:0]     br_is_branch;
    logic [NW*LN-1:0]  br_taken_lanes;
    logic [NW*PW-1:0]  br_target_pc;
    logic [NW*PW-1:0]  br_reconv_pc;
    logic              issue_valid;
    logic [WW-1:0]     issue_warp;
    logic [PW-1:0]     issue_pc;
    logic [LN-1:0]     issue_mask;
    logic              overflow_err;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    warp_issue_sched #(
        .NUM_WARPS (NW), .LANES (LN), .PC_W (PW), .STACK_DEPTH (4)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .launch_valid (launch_valid), .launch_warp (launch_warp),
        .launch_pc (launch_pc), .launch_mask (launch_mask),
        .mem_pending (mem_pending), .br_is_branch (br_is_branch),
        .br_taken_lanes (br_taken_lanes), .br_target_pc (br_target_pc),
        .br_reconv_pc (br_reconv_pc), .issue_valid (issue_valid),
        .issue_warp (issue_warp), .issue_pc (issue_pc),
        .issue_mask (issue_mask), .overflow_err (overflow_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one clock; returns just after the falling edge, then settle
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #5;
    endtask

    task automatic set_instr(input int w, input logic br, input logic [LN-1:0] tk,
                             input logic [PW-1:0] tgt, input logic [PW-1:0] rc);
        br_is_branch[w]            = br;
        br_taken_lanes[w*LN +: LN] = tk;
        br_target_pc[w*PW +: PW]   = tgt;
        br_reconv_pc[w*PW +: PW]   = rc;
    endtask

    task automatic launch(input int w, input logic [PW-1:0] p, input logic [LN-1:0] m);
        launch_valid = 1'b1;
        launch_warp  = WW'(w);
        launch_pc    = p;
        launch_mask  = m;
        step();
        launch_valid = 1'b0;
    endtask

    task automatic expect_issue(input string req, input int w, input int p, input logic [LN-1:0] m);
        chk({req, " valid"}, 64'(issue_valid), 64'd1);
        chk({req, " warp"},  64'(issue_warp),  64'(w));
        chk({req, " pc"},    64'(issue_pc),    64'(p));
        chk({req, " mask"},  64'(issue_mask),  64'(m));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; launch_valid = 1'b0; launch_warp = '0; launch_pc = '0;
        launch_mask = '0; mem_pending = '0; br_is_branch = '0;
        br_taken_lanes = '0; br_target_pc = '0; br_reconv_pc = '0;
        @(negedge clk); step(); step();
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 valid", 64'(issue_valid), 64'd0);
        chk("R1 ovf", 64'(overflow_err), 64'd0);

        // R2: launch warp 0, full mask
        launch(0, 16'd100, 32'hFFFF_FFFF);
        expect_issue("R2", 0, 100, 32'hFFFF_FFFF);

        // R7: split branch, low half taken
        set_instr(0, 1'b1, 32'h0000_FFFF, 16'd200, 16'd300);
        step();
        expect_issue("R7", 0, 200, 32'h0000_FFFF);

        // R8: taken path reaches reconvergence -> fall-through path
        set_instr(0, 1'b1, 32'hFFFF_FFFF, 16'd300, 16'd0);
        step();
        expect_issue("R8", 0, 101, 32'hFFFF_0000);

        // R6: unanimous not-taken keeps mask, PC+1
        set_instr(0, 1'b1, 32'h0, 16'd999, 16'd0);
        step();
        expect_issue("R6 fall", 0, 102, 32'hFFFF_0000);

        // R5: pending warp not issued, state held
        mem_pending = 4'b0001;
        #1;
        chk("R5 stall valid", 64'(issue_valid), 64'd0);
        step();
        mem_pending = 4'b0000;
        #1;
        expect_issue("R5 hold", 0, 102, 32'hFFFF_0000);

        // R9: fall-through reaches reconvergence -> pop, restore mask
        set_instr(0, 1'b1, 32'hFFFF_0000, 16'd300, 16'd0);
        step();
        expect_issue("R9", 0, 300, 32'hFFFF_FFFF);

        // R6: unanimous taken with empty stack
        set_instr(0, 1'b1, 32'hFFFF_FFFF, 16'd50, 16'd0);
        step();
        expect_issue("R6 taken", 0, 50, 32'hFFFF_FFFF);

        // R3: plain instruction advances PC
        set_instr(0, 1'b0, 32'h0, 16'd0, 16'd0);
        step();
        expect_issue("R3 seq", 0, 51, 32'hFFFF_FFFF);

        // R10: four nested splits fill the stack
        set_instr(0, 1'b1, 32'h0000_FFFF, 16'd400, 16'd500);
        step();
        expect_issue("R10 d1", 0, 400, 32'h0000_FFFF);
        set_instr(0, 1'b1, 32'h0000_00FF, 16'd410, 16'd420);
        step();
        expect_issue("R10 d2", 0, 410, 32'h0000_00FF);
        set_instr(0, 1'b1, 32'h0000_000F, 16'd430, 16'd440);
        step();
        expect_issue("R10 d3", 0, 430, 32'h0000_000F);
        set_instr(0, 1'b1, 32'h0000_0003, 16'd450, 16'd460);
        step();
        expect_issue("R10 d4", 0, 450, 32'h0000_0003);
        chk("R11 no ovf yet", 64'(overflow_err), 64'd0);

        // R11: fifth split overflows, warp follows taken path
        set_instr(0, 1'b1, 32'h0000_0001, 16'd470, 16'd480);
        step();
        expect_issue("R11", 0, 470, 32'h0000_0001);
        chk("R11 ovf set", 64'(overflow_err), 64'd1);

        // R10: innermost stored entry unwinds first
        set_instr(0, 1'b1, 32'hFFFF_FFFF, 16'd460, 16'd0);
        step();
        expect_issue("R10 unwind", 0, 431, 32'h0000_000C);

        // Launch all warps while stalled; last issued stays warp 0
        set_instr(0, 1'b0, 32'h0, 16'd0, 16'd0);
        mem_pending = 4'b1111;
        launch(1, 16'd1000, 32'hFFFF_FFFF);
        launch(2, 16'd2000, 32'hFFFF_FFFF);
        launch(3, 16'd3000, 32'hFFFF_FFFF);
        launch(0, 16'd0,    32'hFFFF_FFFF);
        chk("R11 sticky", 64'(overflow_err), 64'd1);
        chk("R5 all pending", 64'(issue_valid), 64'd0);
        mem_pending = 4'b0000;
        #1;

        // R12/R4: back-to-back switching in rotation
        expect_issue("R12 a", 1, 1000, 32'hFFFF_FFFF);
        step();
        expect_issue("R12 b", 2, 2000, 32'hFFFF_FFFF);
        step();
        expect_issue("R12 c", 3, 3000, 32'hFFFF_FFFF);
        step();
        expect_issue("R12 d", 0, 0, 32'hFFFF_FFFF);
        step();
        expect_issue("R4 wrap", 1, 1001, 32'hFFFF_FFFF);
        step();

        // R4/R5: sweep every last-issued warp against every pending pattern
        for (int k = 0; k < NW; k++) begin
            for (int p = 0; p < (1 << NW); p++) begin
                int expw;
                mem_pending = ~(NW'(1) << k);
                #1;
                chk("R4 setup", 64'(issue_warp), 64'(k));
                step();
                mem_pending = ~NW'(p);
                #1;
                expw = -1;
                for (int off = 1; off <= NW; off++) begin
                    if (expw < 0 && p[(k + off) % NW]) expw = (k + off) % NW;
                end
                if (expw < 0) begin
                    chk("R5 none ready", 64'(issue_valid), 64'd0);
                end else begin
                    chk("R4 valid", 64'(issue_valid), 64'd1);
                    chk("R4 grant", 64'(issue_warp), 64'(expw));
                end
                step();
            end
        end

        finish_run();
    end
endmodule